// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block sits between a 36-bit long-word datapath and a narrower side port that is either 9 bits wide (byte mode) or 18 bits wide (word mode). It carries traffic both ways at once. The unpack direction takes one long word and hands it out as a run of narrow transfers. The pack direction gathers narrow transfers and offers them as one long word. All four ports use valid/ready handshakes on one clock.

The order of the narrow pieces in both directions comes from an endian select bit. The block samples this bit, together with the bus-size input, on every clock edge while reset is asserted. The value present at the last edge before reset releases is kept until the next reset. Storage in depth and clock-domain crossing sit outside the block.

Top module: `bus_width_matcher`

## Requirements
- R1: On the first cycle after reset, `wide_in_ready` and `nar_in_ready` are 1, and `nar_out_valid` and `wide_out_valid` are 0.
- R2: `cfg_word_mode` = 0 selects byte mode: a long word is four 9-bit transfers on bits [8:0] of the narrow buses. `cfg_word_mode` = 1 selects word mode: a long word is two 18-bit transfers on bits [17:0].
- R3: With the big-endian setting, the unpack side sends the most significant piece of the long word first and the least significant piece last. In byte mode the pieces are bits [35:27], [26:18], [17:9], [8:0]. In word mode they are [35:18], [17:0].
- R4: With the little-endian setting, the unpack side sends the least significant piece first and the most significant piece last.
- R5: With the big-endian setting, the pack side puts the first narrow transfer into the most significant piece of the long word and the last into the least significant piece.
- R6: With the little-endian setting, the pack side puts the first narrow transfer into the least significant piece and the last into the most significant piece.
- R7: `endian_sel` and `cfg_word_mode` are sampled only while `rst_n` is 0. 1 means big-endian and 0 means little-endian. Changes to either input while `rst_n` is 1 have no effect on ordering or width.
- R8: `wide_in_ready` is 0 from the cycle after a long word is accepted until the last narrow piece of that word has been taken. It is 1 again in the following cycle.
- R9: `wide_out_valid` rises only in the cycle after the final narrow piece of a long word is accepted. `nar_in_ready` stays 0 while the finished word waits. A reset discards a partly built word.
- R10: While a valid output is stalled by its ready being 0, the valid stays 1 and the data stays unchanged.
- R11: In byte mode, `nar_out_data[17:9]` is 0 and `nar_in_data[17:9]` has no effect on the assembled long word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while low |
| cfg_word_mode | input | 1 | Narrow bus size: 0 byte (9 bits), 1 word (18 bits) |
| endian_sel | input | 1 | Piece order: 1 big-endian, 0 little-endian |
| wide_in_valid | input | 1 | Long word offered for unpacking |
| wide_in_ready | output | 1 | Unpacker can take a long word |
| wide_in_data | input | 36 | Long word to unpack |
| nar_out_valid | output | 1 | Narrow piece available |
| nar_out_ready | input | 1 | Consumer takes the narrow piece |
| nar_out_data | output | 18 | Narrow piece; upper 9 bits are 0 in byte mode |
| nar_in_valid | input | 1 | Narrow piece offered for packing |
| nar_in_ready | output | 1 | Packer can take a narrow piece |
| nar_in_data | input | 18 | Narrow piece to pack; upper 9 bits are ignored in byte mode |
| wide_out_valid | output | 1 | Assembled long word available |
| wide_out_ready | input | 1 | Consumer takes the long word |
| wide_out_data | output | 36 | Assembled long word |

## Verification
The embedded properties assume that the bus size and endian inputs are meant to take effect only through reset. They also assume that an upstream valid, once raised, may drop only after its handshake, so that the stall checks compare like with like. The stimulus sets both configuration inputs only inside a reset pulse and then drives `endian_sel` to the opposite value on purpose, which leaves ordering as the only evidence of which value was captured. It raises each valid at a falling edge and holds it there until the transfer completes, and it inserts downstream stalls on alternate words in each of the four mode and endian combinations.

// File: rtl/bwm_pkg.sv
// Package: shared types for the bus width matcher.
// Assumes nothing beyond being compiled before the modules that import it.
package bwm_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } bus_size_e;
endpackage

// File: rtl/bwm_cfg_latch.sv
// Module: holds the bus size and endian choice that reset sampled.
// Assumes: the inputs are sampled on every edge with rst_n low; the value at
// the last such edge stays in effect until the next reset.
module bwm_cfg_latch
    import bwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bus_size_e size_in,
    input  logic      endian_in,
    output bus_size_e size_q,
    output logic      big_q
);
    // Capture the configuration only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= size_in;
            big_q  <= endian_in;
        end
    end
endmodule

// File: rtl/bwm_step_ctr.sv
// Module: counts the narrow pieces of one long word and maps the count to a
// piece position according to the endian setting.
// Assumes: LANES is a power of two of at least 4; word mode uses LANES/2 pieces.
module bwm_step_ctr
    import bwm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int PW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  bus_size_e     size_q,
    input  logic          big_q,
    output logic [PW-1:0] pos,
    output logic          last
);
    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;

    // Index of the final piece for the selected bus size.
    always_comb begin
        lim  = (size_q == SZ_WORD) ? PW'(LANES / 2 - 1) : PW'(LANES - 1);
        last = (cnt == lim);
        pos  = big_q ? (lim - cnt) : cnt;
    end

    // Advance the piece count and wrap it after the final piece.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (advance) cnt <= last ? '0 : cnt + PW'(1);
    end
endmodule

// File: rtl/bwm_unpack.sv
// Module: splits one long word into narrow pieces.
// Assumes: the configuration stays fixed outside reset; a new long word is
// accepted only when no piece of the previous one is left.
module bwm_unpack
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int NARROW_W = 2 * LANE_W,
    localparam int LONG_W   = LANE_W * LANES,
    localparam int PW       = $clog2(LANES),
    localparam int WPW      = $clog2(LANES / 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_size_e           size_q,
    input  logic                big_q,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LONG_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NARROW_W-1:0] out_data
);
    logic              busy;
    logic [LONG_W-1:0] hold;
    logic [PW-1:0]     pos;
    logic              last;
    logic              take;
    logic [WPW-1:0]    wpos;

    assign take      = busy && out_ready;
    assign in_ready  = !busy;
    assign out_valid = busy;
    assign wpos      = pos[WPW-1:0];

    bwm_step_ctr #(.LANES(LANES)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (take),
        .size_q  (size_q),
        .big_q   (big_q),
        .pos     (pos),
        .last    (last)
    );

    // Load a long word when idle; release it after the final piece leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (in_valid && !busy) begin
            busy <= 1'b1;
            hold <= in_data;
        end else if (take && last) begin
            busy <= 1'b0;
        end
    end

    // Select the current piece; byte mode zero-fills the upper half.
    always_comb begin
        if (size_q == SZ_WORD) out_data = hold[wpos*NARROW_W +: NARROW_W];
        else                   out_data = NARROW_W'(hold[pos*LANE_W +: LANE_W]);
    end

    a_r10_unpack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r8_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && !in_ready);
    a_r8_last_frees: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && last |=> in_ready);
endmodule

// File: rtl/bwm_pack.sv
// Module: gathers narrow pieces into one long word.
// Assumes: the configuration stays fixed outside reset; the finished word
// blocks new pieces until it has been taken.
module bwm_pack
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int NARROW_W = 2 * LANE_W,
    localparam int LONG_W   = LANE_W * LANES,
    localparam int PW       = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  bus_size_e           size_q,
    input  logic                big_q,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NARROW_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [LONG_W-1:0]   out_data
);
    logic          full;
    logic [PW-1:0] pos;
    logic          last;
    logic          take;

    assign take      = in_valid && !full;
    assign in_ready  = !full;
    assign out_valid = full;

    bwm_step_ctr #(.LANES(LANES)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (take),
        .size_q  (size_q),
        .big_q   (big_q),
        .pos     (pos),
        .last    (last)
    );

    // One writer per byte lane of the assembled long word.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        logic [LANE_W-1:0] src;
        // Decide whether this lane is the target and pick its source bits.
        always_comb begin
            if (size_q == SZ_WORD) begin
                hit = (pos == PW'(i / 2));
                src = in_data[(i % 2)*LANE_W +: LANE_W];
            end else begin
                hit = (pos == PW'(i));
                src = in_data[LANE_W-1:0];
            end
        end
        // Store the piece into this lane when it is accepted.
        always_ff @(posedge clk) begin
            if (take && hit) out_data[i*LANE_W +: LANE_W] <= src;
        end
    end

    // Mark the word complete on the final piece; clear it when taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                full <= 1'b0;
        else if (take && last)     full <= 1'b1;
        else if (full && out_ready) full <= 1'b0;
    end

    a_r10_pack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    a_r9_complete: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && last |=> out_valid && !in_ready);
    a_r9_no_early: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !last |=> !out_valid);
endmodule

// File: rtl/bus_width_matcher.sv
// Module: two-way width converter between a long-word port and a 9- or 18-bit
// port with an endian order fixed at reset.
// Assumes: single clock; cfg_word_mode and endian_sel matter only during reset.
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    localparam int NARROW_W = 2 * LANE_W,
    localparam int LONG_W   = LANE_W * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_word_mode,
    input  logic                endian_sel,
    input  logic                wide_in_valid,
    output logic                wide_in_ready,
    input  logic [LONG_W-1:0]   wide_in_data,
    output logic                nar_out_valid,
    input  logic                nar_out_ready,
    output logic [NARROW_W-1:0] nar_out_data,
    input  logic                nar_in_valid,
    output logic                nar_in_ready,
    input  logic [NARROW_W-1:0] nar_in_data,
    output logic                wide_out_valid,
    input  logic                wide_out_ready,
    output logic [LONG_W-1:0]   wide_out_data
);
    bus_size_e size_q;
    logic      big_q;

    bwm_cfg_latch u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_in   (bus_size_e'(cfg_word_mode)),
        .endian_in (endian_sel),
        .size_q    (size_q),
        .big_q     (big_q)
    );

    bwm_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_q    (size_q),
        .big_q     (big_q),
        .in_valid  (wide_in_valid),
        .in_ready  (wide_in_ready),
        .in_data   (wide_in_data),
        .out_valid (nar_out_valid),
        .out_ready (nar_out_ready),
        .out_data  (nar_out_data)
    );

    bwm_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_q    (size_q),
        .big_q     (big_q),
        .in_valid  (nar_in_valid),
        .in_ready  (nar_in_ready),
        .in_data   (nar_in_data),
        .out_valid (wide_out_valid),
        .out_ready (wide_out_ready),
        .out_data  (wide_out_data)
    );

    a_r11_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        nar_out_valid && size_q == SZ_BYTE |-> nar_out_data[NARROW_W-1:LANE_W] == '0);
endmodule

// File: tb/bus_width_matcher_bench.sv
module bus_width_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_word_mode = 1'b0;
    logic        endian_sel = 1'b0;
    logic        wide_in_valid = 1'b0;
    logic        wide_in_ready;
    logic [35:0] wide_in_data = '0;
    logic        nar_out_valid;
    logic        nar_out_ready = 1'b0;
    logic [17:0] nar_out_data;
    logic        nar_in_valid = 1'b0;
    logic        nar_in_ready;
    logic [17:0] nar_in_data = '0;
    logic        wide_out_valid;
    logic        wide_out_ready = 1'b0;
    logic [35:0] wide_out_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bus_width_matcher u_bus_width_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_word_mode(cfg_word_mode), .endian_sel(endian_sel),
        .wide_in_valid(wide_in_valid), .wide_in_ready(wide_in_ready), .wide_in_data(wide_in_data),
        .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready), .nar_out_data(nar_out_data),
        .nar_in_valid(nar_in_valid), .nar_in_ready(nar_in_ready), .nar_in_data(nar_in_data),
        .wide_out_valid(wide_out_valid), .wide_out_ready(wide_out_ready), .wide_out_data(wide_out_data)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic wm, input logic be);
        @(negedge clk);
        rst_n = 1'b0; cfg_word_mode = wm; endian_sel = be;
        wide_in_valid = 0; nar_out_ready = 0; nar_in_valid = 0; wide_out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        endian_sel = ~be;        // R7: must be ignored from here on
        cfg_word_mode = ~wm;     // R7: must be ignored from here on
        @(negedge clk);
    endtask

    function automatic logic [17:0] slice(input logic [35:0] w, input int p, input logic wm);
        if (wm) return 18'((w >> (p * 18)) & 36'h3FFFF);
        else    return 18'((w >> (p * 9)) & 36'h1FF);
    endfunction

    task automatic unpack_one(input logic [35:0] w, input logic wm, input logic be, input bit stall);
        int n = wm ? 2 : 4;
        wide_in_data = w; wide_in_valid = 1'b1;
        @(negedge clk);
        wide_in_valid = 1'b0;
        check("R8 busy after accept", {63'b0, wide_in_ready}, 64'd0);
        for (int k = 0; k < n; k++) begin
            int p = be ? n - 1 - k : k;
            string tag = be ? "R3 unpack order" : "R4 unpack order";
            if (stall) begin
                @(negedge clk);
                check("R10 unpack stall valid", {63'b0, nar_out_valid}, 64'd1);
            end
            check(wm ? {tag, " R2 word"} : {tag, " R2 R11 byte"},
                  {46'b0, nar_out_data}, {46'b0, slice(w, p, wm)});
            if (k < n - 1) check("R8 still busy", {63'b0, wide_in_ready}, 64'd0);
            nar_out_ready = 1'b1;
            @(negedge clk);
            nar_out_ready = 1'b0;
        end
        check("R8 ready after last", {62'b0, wide_in_ready, nar_out_valid}, 64'd2);
    endtask

    task automatic pack_one(input logic [35:0] w, input logic wm, input logic be, input bit stall);
        int n = wm ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            int p = be ? n - 1 - k : k;
            check("R9 no early valid", {63'b0, wide_out_valid}, 64'd0);
            nar_in_data = wm ? slice(w, p, 1'b1) : {9'(9'h1A5 ^ k), slice(w, p, 1'b0)[8:0]};
            nar_in_valid = 1'b1;
            @(negedge clk);
            nar_in_valid = 1'b0;
        end
        check("R9 complete, blocked", {62'b0, wide_out_valid, nar_in_ready}, 64'd2);
        check(be ? (wm ? "R5 R2 pack word" : "R5 R11 pack byte") : (wm ? "R6 R2 pack word" : "R6 R11 pack byte"),
              {28'b0, wide_out_data}, {28'b0, w});
        if (stall) begin
            @(negedge clk);
            check("R10 pack stall", {27'b0, wide_out_valid, wide_out_data}, {27'b0, 1'b1, w});
        end
        wide_out_ready = 1'b1;
        @(negedge clk);
        wide_out_ready = 1'b0;
        check("R9 released", {62'b0, wide_out_valid, nar_in_ready}, 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
                logic wm = 1'(m);
                logic be = 1'(b);
                do_reset(wm, be);
                check("R1 reset state",
                      {60'b0, wide_in_ready, nar_in_ready, nar_out_valid, wide_out_valid},
                      64'hC);
                for (int i = 0; i < 6; i++) begin
                    logic [35:0] w = 36'(i * 36'h9E3779B97 + m * 36'h123456789 + b * 36'h0F0F0F0F1);
                    unpack_one(w, wm, be, i[0]);
                    pack_one(~w, wm, be, i[0]);
                end
                // R9: a partly built word is dropped by reset
                nar_in_data = 18'h3FFFF; nar_in_valid = 1'b1;
                @(negedge clk);
                nar_in_valid = 1'b0;
                do_reset(wm, be);
                check("R9 partial discarded", {63'b0, wide_out_valid}, 64'd0);
                pack_one(36'h8_1234_5678, wm, be, 1'b0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule